// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block is a register-mapped GPIO controller for four 8-bit ports (32 pads). Software reaches it over a simple 32-bit register bus with a byte address, a write strobe, write data, a read strobe and read data. For each port there is a configuration word that puts a pin under GPIO control, an output-enable word, an output-value word and a read-only word holding the synchronized pad inputs. Four interrupt-related words (status, enable, level, clear) are plain storage: they can be read and written but detect nothing.

Each writable word also appears at a second address, 0x80 above the normal one. A write there changes only chosen pins: the upper byte of the write data selects the pins, and the lower byte gives their new levels. Firmware can therefore flip one pin of a shared port without a read-modify-write sequence. Writes update the registers on the clock edge. Reads are combinational from register state, so a read issued in the cycle after a write already sees the new value.

A pad number is port × 8 + pin. Pad n drives `pad_oe[n]` and `pad_out[n]` and is sampled from `pad_in[n]`.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration, output-enable, output-value and interrupt word reads 0, and `pad_oe` is all zero.
- R2: Byte address bits [6:4] select the group: 0 configuration, 1 output enable, 2 output value, 3 input value, 4 interrupt status, 5 interrupt enable, 6 interrupt level, 7 interrupt clear. Bits [3:2] select the port. A read returns that port's 8 pins in bits [7:0], with bits [31:8] at zero.
- R3: A write with address bit 7 clear replaces all 8 pins of the addressed word from write data bits [7:0]. Write data bits [31:8] have no effect.
- R4: A write with address bit 7 set updates pin i only when write data bit (8+i) is 1, loading write data bit i. Every other pin keeps its value.
- R5: A read in the cycle right after a write returns the value that write produced.
- R6: The input-value word is read-only. Normal and masked writes to it change nothing.
- R7: A change on `pad_in` becomes visible in the input-value word after exactly two rising clock edges.
- R8: `pad_oe[n]` is 1 only when both the configuration bit and the output-enable bit of pad n are 1. `pad_out[n]` follows the output-value bit of pad n.
- R9: The four interrupt words store and read back what is written, and writing them does not change `pad_oe` or `pad_out`.
- R10: While `bus_re` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address inside the bank |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_re |
| pad_in | input | 32 | Raw pad inputs, asynchronous |
| pad_oe | output | 32 | Per-pad output enable |
| pad_out | output | 32 | Per-pad output level |

## Verification
The bench targets the masked-write corner cases: an all-clear mask that must leave the word untouched, an all-set mask that must act like a normal write, and stray high data bits on normal writes. A design that swapped mask and value bytes, or let bits [31:8] leak in, would corrupt neighbouring pins. It also writes into the input word through both addresses; a design that decoded it as writable would show the written data in place of the pads. It samples the input word after one and after two edges to catch a synchronizer that is one stage too short or too long. It sets output enable with the configuration bit clear, which exposes a design that drives pads without GPIO control.

// File: rtl/gpio_bank_pkg.sv
// Package: shared group encoding and address-field positions for the GPIO bank.
// Assumes the byte address layout: [7] alias select, [6:4] group, [3:2] port slot.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        GRP_CFG  = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_ISTA = 3'd4,
        GRP_IENB = 3'd5,
        GRP_ILVL = 3'd6,
        GRP_ICLR = 3'd7
    } grp_e;

    localparam int NUM_GROUPS = 8;
    localparam int ALIAS_BIT  = 7;
    localparam int GRP_LSB    = 4;
    localparam int SLOT_LSB   = 2;

endpackage

// File: rtl/gpio_port_reg.sv
// One 8-pin storage word of one port. A normal write replaces all pins;
// a masked write changes only the pins whose enable bit (upper half) is set.
// Assumes wr_en is already qualified by address decode.
module gpio_port_reg #(
    parameter int PIN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               masked,
    input  logic [2*PIN_W-1:0] wdata,
    output logic [PIN_W-1:0]   q
);
    logic [PIN_W-1:0] sel;
    logic [PIN_W-1:0] nxt;

    // Choose which pins take new data: all for a normal write, enabled ones for masked.
    always_comb begin
        sel = masked ? wdata[2*PIN_W-1:PIN_W] : '1;
        nxt = (q & ~sel) | (wdata[PIN_W-1:0] & sel);
    end

    // Register the word with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= nxt;
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for the asynchronous pad inputs.
// Assumes STAGES >= 2; the last stage output is what software reads.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pad sample through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_rd_mux.sv
// Read path: picks one port word out of all group words and zero-extends it.
// Assumes regs are packed group-major, then port, PIN_W bits per word.
module gpio_rd_mux #(
    parameter int NUM_PORTS = 4,
    parameter int PIN_W     = 8,
    parameter int DATA_W    = 32,
    parameter int NGRP      = 8,
    localparam int SLOT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOTAL    = NGRP * NUM_PORTS * PIN_W
) (
    input  logic              re,
    input  logic [2:0]        grp,
    input  logic [SLOT_W-1:0] slot,
    input  logic [TOTAL-1:0]  regs,
    output logic [DATA_W-1:0] rdata
);
    // Combinational select so a read sees the state committed at the last edge.
    always_comb begin
        rdata = '0;
        if (re)
            rdata[PIN_W-1:0] = regs[(int'(grp) * NUM_PORTS + int'(slot)) * PIN_W +: PIN_W];
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: four ports of storage words, a masked-write alias at +0x80,
// a synchronized input word and pad output gating (cfg AND oe).
// Assumes a single-cycle bus: writes commit at the clock edge, reads are combinational.
module gpio_bank #(
    parameter int NUM_PORTS   = 4,
    parameter int PIN_W       = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_re,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PORTS*PIN_W-1:0] pad_in,
    output logic [NUM_PORTS*PIN_W-1:0] pad_oe,
    output logic [NUM_PORTS*PIN_W-1:0] pad_out
);
    import gpio_bank_pkg::*;

    localparam int PADS   = NUM_PORTS * PIN_W;
    localparam int SLOT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int TOTAL  = NUM_GROUPS * PADS;

    logic              is_alias;
    logic [2:0]        grp;
    logic [SLOT_W-1:0] slot;
    logic [TOTAL-1:0]  regs;
    logic [PADS-1:0]   in_sync;
    logic              unused_bits;

    // Split the byte address into alias select, group and port slot.
    always_comb begin
        is_alias = bus_addr[ALIAS_BIT];
        grp      = bus_addr[GRP_LSB +: 3];
        slot     = bus_addr[SLOT_LSB +: SLOT_W];
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:2*PIN_W]};

    gpio_in_sync #(.W(PADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            if (g == int'(GRP_IN)) begin : g_ro
                assign regs[(g*NUM_PORTS + p)*PIN_W +: PIN_W] = in_sync[p*PIN_W +: PIN_W];
            end else begin : g_rw
                logic hit;
                assign hit = bus_we && (grp == 3'(g)) && (slot == SLOT_W'(p));
                gpio_port_reg #(.PIN_W(PIN_W)) u_reg (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .wr_en  (hit),
                    .masked (is_alias),
                    .wdata  (bus_wdata[2*PIN_W-1:0]),
                    .q      (regs[(g*NUM_PORTS + p)*PIN_W +: PIN_W])
                );
            end
        end
    end

    gpio_rd_mux #(.NUM_PORTS(NUM_PORTS), .PIN_W(PIN_W), .DATA_W(DATA_W), .NGRP(NUM_GROUPS)) u_rd (
        .re    (bus_re),
        .grp   (grp),
        .slot  (slot),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    // Drive a pad only when it is under GPIO control and enabled as output.
    always_comb begin
        pad_oe  = regs[int'(GRP_CFG)*PADS +: PADS] & regs[int'(GRP_OE)*PADS +: PADS];
        pad_out = regs[int'(GRP_OUT)*PADS +: PADS];
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Checker for gpio_bank, observing only its ports. Bound to every instance below.
module gpio_bank_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PIN_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_re,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_PORTS*PIN_W-1:0] pad_oe,
    input logic [NUM_PORTS*PIN_W-1:0] pad_out
);
    localparam int PADS = NUM_PORTS * PIN_W;

    function automatic logic [PIN_W-1:0] port_of(logic [PADS-1:0] v, logic [1:0] s);
        return v[int'(s)*PIN_W +: PIN_W];
    endfunction

    logic out_norm, out_mask, cfg_clr, int_wr;
    // Classify the current bus write for the properties below.
    always_comb begin
        out_norm = bus_we && !bus_addr[7] && bus_addr[6:4] == 3'd2;
        out_mask = bus_we &&  bus_addr[7] && bus_addr[6:4] == 3'd2;
        cfg_clr  = bus_we && !bus_addr[7] && bus_addr[6:4] == 3'd0 && bus_wdata[PIN_W-1:0] == '0;
        int_wr   = bus_we && bus_addr[6];
    end

    a_r1_reset_oe_low: assert property (@(posedge clk)
        !rst_n |=> pad_oe == '0);

    a_r3_normal_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_norm |=> port_of(pad_out, $past(bus_addr[3:2])) == $past(bus_wdata[PIN_W-1:0]));

    a_r4_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask |=> port_of(pad_out, $past(bus_addr[3:2])) ==
            (($past(bus_wdata[2*PIN_W-1:PIN_W]) & $past(bus_wdata[PIN_W-1:0])) |
             (~$past(bus_wdata[2*PIN_W-1:PIN_W]) & port_of($past(pad_out), $past(bus_addr[3:2])))));

    a_r8_cfg_gates_oe: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> port_of(pad_oe, $past(bus_addr[3:2])) == '0);

    a_r9_int_no_pad_effect: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr |=> ($stable(pad_oe) && $stable(pad_out)));

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> bus_rdata == '0);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> bus_rdata[DATA_W-1:PIN_W] == '0);
endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PIN_W     (PIN_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [8][4];

    always #2.5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [7:0] merge(logic [7:0] old, logic [31:0] wd, bit msk);
        logic [7:0] en;
        en = msk ? wd[15:8] : 8'hFF;
        return (old & ~en) | (wd[7:0] & en);
    endfunction

    function automatic logic [7:0] addr_of(int g, int s, bit msk);
        return 8'((msk ? 8'h80 : 8'h00) + g * 16 + s * 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int g, int s, bit msk, logic [31:0] d);
        @(negedge clk);
        bus_addr = addr_of(g, s, msk); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (g != 3) mdl[g][s] = merge(mdl[g][s], d, msk);
    endtask

    // Read at the current negedge; data is combinational.
    task automatic rd_chk(string req, int g, int s);
        logic [31:0] exp;
        bus_addr = addr_of(g, s, 1'b0); bus_re = 1'b1;
        #1;
        exp = (g == 3) ? {24'h0, pad_in[s*8 +: 8]} : {24'h0, mdl[g][s]};
        check(req, bus_rdata, exp);
        bus_re = 1'b0;
    endtask

    function automatic logic [31:0] exp_oe();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) v[s*8 +: 8] = mdl[0][s] & mdl[1][s];
        return v;
    endfunction

    function automatic logic [31:0] exp_out();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) v[s*8 +: 8] = mdl[2][s];
        return v;
    endfunction

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int g = 0; g < 8; g++) for (int s = 0; s < 4; s++) mdl[g][s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state of every stored word and the pad enables
        @(negedge clk);
        for (int g = 0; g < 8; g++) if (g != 3) for (int s = 0; s < 4; s++) rd_chk("R1", g, s);
        check("R1 pad_oe", pad_oe, 32'h0);

        // R10: idle read data is zero
        bus_addr = addr_of(2, 1, 1'b0); #1;
        check("R10", bus_rdata, 32'h0);

        // R3: normal write ignores upper data bits; R5 read right after write
        wr(2, 1, 1'b0, 32'hDEAD_BE5A);
        rd_chk("R3/R5", 2, 1);
        check("R8 pad_out", pad_out, exp_out());

        // R4: empty mask changes nothing, full mask acts as normal write, partial mask
        wr(2, 1, 1'b1, 32'h0000_00FF);
        rd_chk("R4 empty mask", 2, 1);
        wr(2, 1, 1'b1, 32'h0000_FF81);
        rd_chk("R4 full mask", 2, 1);
        wr(2, 1, 1'b1, 32'h0000_0C04);
        rd_chk("R4 partial mask", 2, 1);

        // R8: oe set but cfg clear keeps pad undriven; then cfg set drives it
        wr(1, 3, 1'b0, 32'hFF);
        check("R8 cfg clear", pad_oe, 32'h0);
        wr(0, 3, 1'b1, 32'h0F0F);
        check("R8 cfg set", pad_oe, exp_oe());

        // R9: interrupt words store data and leave pads alone
        for (int g = 4; g < 8; g++) begin
            wr(g, g - 4, g[0], 32'h0000_A55A);
            rd_chk("R9", g, g - 4);
            check("R9 pad_oe", pad_oe, exp_oe());
            check("R9 pad_out", pad_out, exp_out());
        end

        // R7: input word shows a pad change after exactly two edges
        @(negedge clk); pad_in = 32'hC3A5_5A3C;
        @(negedge clk);
        bus_addr = addr_of(3, 2, 1'b0); bus_re = 1'b1; #1;
        check("R7 one edge", bus_rdata, 32'h0);
        bus_re = 1'b0;
        @(negedge clk);
        rd_chk("R7 two edges", 3, 2);

        // R6: writes to the input word through both addresses are ignored
        wr(3, 2, 1'b0, 32'h0000_00FF);
        rd_chk("R6 normal", 3, 2);
        wr(3, 0, 1'b1, 32'h0000_FF00);
        rd_chk("R6 masked", 3, 0);

        // R2/R3/R4: random mix over all groups, ports and both addresses
        for (int i = 0; i < 400; i++) begin
            int g, s;
            bit m;
            g = int'($urandom_range(7)); s = int'($urandom_range(3)); m = 1'($urandom);
            if ($urandom_range(15) == 0) begin
                @(negedge clk); pad_in = $urandom;
                repeat (2) @(negedge clk);
            end
            wr(g, s, m, $urandom);
            rd_chk("R2 random", g, s);
            rd_chk("R2 random other", int'($urandom_range(7)), int'($urandom_range(3)));
            check("R8 random oe", pad_oe, exp_oe());
            check("R8 random out", pad_out, exp_out());
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule